// File: doc/BRIEF.md
# Cipher Core Register Front-End (APB)

This block is an APB slave register bank that sits in front of a block-cipher engine. Software writes the key, the data block and a command word through the bus. The block holds those values and drives them onto the engine's port-level interface. The engine's ready flag, its result-valid flag and its 128-bit result are brought back into the address map so that software can read them. The cipher itself lives outside this block.

Commands to the engine are short strobes. A control write that sets the key-start bit or the block-start bit produces a single-cycle pulse on the matching engine input. The direction bit and the key-width bit stay at the values last written.

A two-source interrupt unit watches the engine's result-valid and ready flags. It latches a raw flag on each rising edge, masks the raw flags with a software-written enable word, and drives one interrupt line.

Top module: `cipher_apb_wrap`

## Requirements
- R1: After reset, every readable offset returns 0. The key, block, direction and key-width outputs are 0, both command pulses are low, and the interrupt line is low.
- R2: A write to offset 0x04 with bit 0 set drives `core_key_init` high for exactly one cycle, in the cycle after the APB access phase. Bit 1 does the same for `core_block_next`. A write with the bit clear produces no pulse.
- R3: Bit 2 of the offset 0x04 write drives `core_encrypt` (1 = encrypt, 0 = decrypt). Bit 3 drives `core_wide_key` (0 = 128-bit key, 1 = 256-bit key). Both hold their values until the next write to that offset.
- R4: A write to offset 0x08+4n (n = 0..7) loads `core_key[32n+31:32n]`, and a write to offset 0x28+4n (n = 0..3) loads `core_block[32n+31:32n]`. All other words keep their values.
- R5: A read of offset 0x00 returns `core_ready` in bit 6 and `core_result_valid` in bit 7. All other bits are 0.
- R6: A read of offset 0x38+4n (n = 0..3) returns `core_result[32n+31:32n]`.
- R7: Raw flag bit 0 (readable at offset 0xFF08) is set on a rising edge of `core_result_valid`, and raw flag bit 1 on a rising edge of `core_ready`. A raw flag stays set after its source falls.
- R8: The enable word is at offset 0xFF00 and can be read and written. Offset 0xFF04 reads as the raw flags AND the enable word, and writes to it have no effect. `irq` is high exactly when any masked bit is 1.
- R9: Writing 1 to a bit at offset 0xFF0C clears that raw flag, and writing 0 leaves it unchanged. If a rising edge of the source and a clear of the same bit happen in the same cycle, the flag ends up set.
- R10: `pready` is always high and `pslverr` is always low. Reads of write-only offsets (0x04, key, block, 0xFF0C) and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and engine clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete (always high) |
| pslverr | output | 1 | Transfer error (always low) |
| irq | output | 1 | Interrupt request |
| core_encrypt | output | 1 | Direction to engine, 1 = encrypt |
| core_wide_key | output | 1 | Key width to engine, 1 = 256-bit |
| core_key_init | output | 1 | One-cycle key start strobe |
| core_block_next | output | 1 | One-cycle block start strobe |
| core_key | output | 256 | Key to engine |
| core_block | output | 128 | Data block to engine |
| core_ready | input | 1 | Engine can accept a command |
| core_result | input | 128 | Engine output block |
| core_result_valid | input | 1 | Engine output block is valid |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 32-bit words, a 256-bit key and a 128-bit block. These values put all eight key words and all four block words in range, so a write to any single word can be shown to leave the other eleven unchanged. They also place the interrupt registers high in the map, which lets the bench test unmapped reads in the gap between the data words and the interrupt words. The bench drives the engine flags itself and can therefore line up a rising edge with a clear write in the same cycle to test the set-over-clear rule.

// File: rtl/cw_pkg.sv
package cw_pkg;

  // Fixed offsets (byte addresses)
  localparam int OFS_STATUS     = 'h0000;
  localparam int OFS_CTRL       = 'h0004;
  localparam int OFS_KEY0       = 'h0008;
  localparam int OFS_IRQ_MASK   = 'hFF00;
  localparam int OFS_IRQ_MASKED = 'hFF04;
  localparam int OFS_IRQ_RAW    = 'hFF08;
  localparam int OFS_IRQ_CLEAR  = 'hFF0C;

  // Interrupt sources
  localparam int NUM_IRQ   = 2;
  localparam int IRQ_VALID = 0;
  localparam int IRQ_READY = 1;

  // Status word bit positions
  localparam int ST_READY_BIT = 6;
  localparam int ST_VALID_BIT = 7;

  // Command word layout, low bits of a control write
  localparam int CTRL_W = 4;
  typedef struct packed {
    logic wide_key;   // bit 3
    logic encrypt;    // bit 2
    logic blk_next;   // bit 1
    logic key_init;   // bit 0
  } ctrl_cmd_t;

endpackage

// File: rtl/cw_reset_sync.sv
module cw_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cw_apb_decode.sv
module cw_apb_decode #(
  parameter int ADDR_W    = 16,
  parameter int KEY_WORDS = 8,
  parameter int BLK_WORDS = 4,
  parameter int KEY_BASE  = 8,
  parameter int BLK_BASE  = 40
) (
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  output logic                 wr_ctrl,
  output logic [KEY_WORDS-1:0] wr_key,
  output logic [BLK_WORDS-1:0] wr_blk,
  output logic                 wr_mask,
  output logic                 wr_clr
);
  import cw_pkg::*;

  logic wr_acc;
  assign wr_acc = psel & penable & pwrite;

  assign wr_ctrl = wr_acc && (paddr == ADDR_W'(OFS_CTRL));
  assign wr_mask = wr_acc && (paddr == ADDR_W'(OFS_IRQ_MASK));
  assign wr_clr  = wr_acc && (paddr == ADDR_W'(OFS_IRQ_CLEAR));

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key_dec
    assign wr_key[g] = wr_acc && (paddr == ADDR_W'(KEY_BASE + 4 * g));
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk_dec
    assign wr_blk[g] = wr_acc && (paddr == ADDR_W'(BLK_BASE + 4 * g));
  end

endmodule

// File: rtl/cw_core_drive.sv
module cw_core_drive #(
  parameter int WORD_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int BLK_WORDS = 4,
  localparam int KEY_W    = WORD_W * KEY_WORDS,
  localparam int BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic [cw_pkg::CTRL_W-1:0] ctrl_wdata,
  input  logic [KEY_WORDS-1:0]  wr_key,
  input  logic [BLK_WORDS-1:0]  wr_blk,
  input  logic [WORD_W-1:0]     wdata,
  output logic                  encrypt,
  output logic                  wide_key,
  output logic                  key_init,
  output logic                  blk_next,
  output logic [KEY_W-1:0]      key,
  output logic [BLK_W-1:0]      block
);
  import cw_pkg::*;

  ctrl_cmd_t cmd;
  assign cmd = ctrl_cmd_t'(ctrl_wdata);

  // Mode bits: held, loaded on a control write
  logic mode_enc_q, mode_wide_q;
  logic mode_enc_d, mode_wide_d;

  always_comb begin
    mode_enc_d  = cmd.encrypt;
    mode_wide_d = cmd.wide_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_enc_q  <= 1'b0;
      mode_wide_q <= 1'b0;
    end else if (wr_ctrl) begin
      mode_enc_q  <= mode_enc_d;
      mode_wide_q <= mode_wide_d;
    end
  end

  // Command strobes: one cycle, self-clearing
  logic [1:0] pulse_q, pulse_d;

  always_comb begin
    pulse_d = 2'b00;
    if (wr_ctrl) pulse_d = {cmd.blk_next, cmd.key_init};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 2'b00;
    else        pulse_q <= pulse_d;
  end

  // Key words
  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (wr_key[g]) word_q <= wdata;
    end
    assign key[g*WORD_W +: WORD_W] = word_q;
  end

  // Block words
  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (wr_blk[g]) word_q <= wdata;
    end
    assign block[g*WORD_W +: WORD_W] = word_q;
  end

  assign encrypt  = mode_enc_q;
  assign wide_key = mode_wide_q;
  assign key_init = pulse_q[0];
  assign blk_next = pulse_q[1];

endmodule

// File: rtl/cw_irq_unit.sv
module cw_irq_unit #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         wr_mask,
  input  logic         wr_clr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);

  logic [N-1:0] src_q, raw_q, mask_q;
  logic [N-1:0] rise, clr_bits, raw_d, mask_d;

  always_comb begin
    rise     = src & ~src_q;
    clr_bits = wr_clr ? wdata : '0;
    // a set event outranks a clear of the same bit
    raw_d    = (raw_q & ~clr_bits) | rise;
    mask_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      raw_q <= '0;
    end else begin
      src_q <= src;
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end

  assign mask   = mask_q;
  assign raw    = raw_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/cw_read_mux.sv
module cw_read_mux #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int RES_BASE  = 56,
  localparam int BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic                        psel,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic                        core_ready,
  input  logic                        core_valid,
  input  logic [BLK_W-1:0]            core_result,
  input  logic [cw_pkg::NUM_IRQ-1:0]  irq_mask,
  input  logic [cw_pkg::NUM_IRQ-1:0]  irq_raw,
  input  logic [cw_pkg::NUM_IRQ-1:0]  irq_masked,
  output logic [WORD_W-1:0]           prdata
);
  import cw_pkg::*;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (paddr == ADDR_W'(OFS_STATUS)) begin
        prdata[ST_READY_BIT] = core_ready;
        prdata[ST_VALID_BIT] = core_valid;
      end
      for (int i = 0; i < BLK_WORDS; i++) begin
        if (paddr == ADDR_W'(RES_BASE + 4 * i))
          prdata = core_result[i*WORD_W +: WORD_W];
      end
      if (paddr == ADDR_W'(OFS_IRQ_MASK))   prdata = WORD_W'(irq_mask);
      if (paddr == ADDR_W'(OFS_IRQ_MASKED)) prdata = WORD_W'(irq_masked);
      if (paddr == ADDR_W'(OFS_IRQ_RAW))    prdata = WORD_W'(irq_raw);
    end
  end

endmodule

// File: rtl/cipher_apb_wrap.sv
module cipher_apb_wrap #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int KEY_W  = 256,
  parameter int BLK_W  = 128
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq,
  output logic              core_encrypt,
  output logic              core_wide_key,
  output logic              core_key_init,
  output logic              core_block_next,
  output logic [KEY_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_block,
  input  logic              core_ready,
  input  logic [BLK_W-1:0]  core_result,
  input  logic              core_result_valid
);
  import cw_pkg::*;

  localparam int KEY_WORDS = KEY_W / WORD_W;
  localparam int BLK_WORDS = BLK_W / WORD_W;
  localparam int KEY_BASE  = OFS_KEY0;
  localparam int BLK_BASE  = KEY_BASE + 4 * KEY_WORDS;
  localparam int RES_BASE  = BLK_BASE + 4 * BLK_WORDS;

  logic                 rst_n;
  logic                 wr_ctrl, wr_mask, wr_clr;
  logic [KEY_WORDS-1:0] wr_key;
  logic [BLK_WORDS-1:0] wr_blk;
  logic [NUM_IRQ-1:0]   irq_src, irq_mask, irq_raw, irq_masked;

  cw_reset_sync #(.STAGES(2)) u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n)
  );

  cw_apb_decode #(
    .ADDR_W    (ADDR_W),
    .KEY_WORDS (KEY_WORDS),
    .BLK_WORDS (BLK_WORDS),
    .KEY_BASE  (KEY_BASE),
    .BLK_BASE  (BLK_BASE)
  ) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wr_ctrl (wr_ctrl),
    .wr_key  (wr_key),
    .wr_blk  (wr_blk),
    .wr_mask (wr_mask),
    .wr_clr  (wr_clr)
  );

  cw_core_drive #(
    .WORD_W    (WORD_W),
    .KEY_WORDS (KEY_WORDS),
    .BLK_WORDS (BLK_WORDS)
  ) u_drv (
    .clk        (pclk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .ctrl_wdata (pwdata[CTRL_W-1:0]),
    .wr_key     (wr_key),
    .wr_blk     (wr_blk),
    .wdata      (pwdata),
    .encrypt    (core_encrypt),
    .wide_key   (core_wide_key),
    .key_init   (core_key_init),
    .blk_next   (core_block_next),
    .key        (core_key),
    .block      (core_block)
  );

  assign irq_src[IRQ_VALID] = core_result_valid;
  assign irq_src[IRQ_READY] = core_ready;

  cw_irq_unit #(.N(NUM_IRQ)) u_irq (
    .clk     (pclk),
    .rst_n   (rst_n),
    .src     (irq_src),
    .wr_mask (wr_mask),
    .wr_clr  (wr_clr),
    .wdata   (pwdata[NUM_IRQ-1:0]),
    .mask    (irq_mask),
    .raw     (irq_raw),
    .masked  (irq_masked),
    .irq     (irq)
  );

  cw_read_mux #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .BLK_WORDS (BLK_WORDS),
    .RES_BASE  (RES_BASE)
  ) u_rd (
    .psel        (psel),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .core_ready  (core_ready),
    .core_valid  (core_result_valid),
    .core_result (core_result),
    .irq_mask    (irq_mask),
    .irq_raw     (irq_raw),
    .irq_masked  (irq_masked),
    .prdata      (prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/cipher_apb_wrap_chk.sv
module cipher_apb_wrap_chk #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [1:0]        wdata_lo,
  input logic [WORD_W-1:0] prdata,
  input logic              core_ready,
  input logic              core_result_valid,
  input logic              core_key_init,
  input logic              core_block_next,
  input logic              irq,
  input logic [1:0]        irq_raw,
  input logic [1:0]        irq_mask
);
  import cw_pkg::*;

  logic prev_valid, prev_ready;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_ready <= 1'b0;
    end else begin
      prev_valid <= core_result_valid;
      prev_ready <= core_ready;
    end
  end

  logic wr_acc;
  assign wr_acc = psel && penable && pwrite;

  p_key_strobe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_key_init |-> $past(wr_acc && paddr == ADDR_W'(OFS_CTRL) && wdata_lo[0]));

  p_blk_strobe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_block_next |-> $past(wr_acc && paddr == ADDR_W'(OFS_CTRL) && wdata_lo[1]));

  p_status_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == ADDR_W'(OFS_STATUS)) |->
      prdata == WORD_W'({core_result_valid, core_ready, 6'b0}));

  p_valid_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_result_valid && !prev_valid) |=> irq_raw[IRQ_VALID]);

  p_ready_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready && !prev_ready) |=> irq_raw[IRQ_READY]);

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irq_raw & irq_mask) != 2'b00));

  p_masked_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == ADDR_W'(OFS_IRQ_MASKED)) |=> $stable(irq_mask));

  p_clear_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == ADDR_W'(OFS_IRQ_CLEAR) && wdata_lo[0] &&
     !(core_result_valid && !prev_valid)) |=> !irq_raw[IRQ_VALID]);

endmodule

bind cipher_apb_wrap cipher_apb_wrap_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk               (pclk),
  .rst_n             (rst_n),
  .psel              (psel),
  .penable           (penable),
  .pwrite            (pwrite),
  .paddr             (paddr),
  .wdata_lo          (pwdata[1:0]),
  .prdata            (prdata),
  .core_ready        (core_ready),
  .core_result_valid (core_result_valid),
  .core_key_init     (core_key_init),
  .core_block_next   (core_block_next),
  .irq               (irq),
  .irq_raw           (irq_raw),
  .irq_mask          (irq_mask)
);

// File: tb/sim_cipher_apb_wrap.sv
`timescale 1ns/1ps
module sim_cipher_apb_wrap;

  logic         pclk = 1'b0;
  logic         presetn;
  logic         psel, penable, pwrite;
  logic [15:0]  paddr;
  logic [31:0]  pwdata;
  logic [31:0]  prdata;
  logic         pready, pslverr, irq;
  logic         core_encrypt, core_wide_key, core_key_init, core_block_next;
  logic [255:0] core_key;
  logic [127:0] core_block;
  logic         core_ready;
  logic [127:0] core_result;
  logic         core_result_valid;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #4 pclk = ~pclk;  // 125 MHz

  cipher_apb_wrap u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq(irq),
    .core_encrypt(core_encrypt), .core_wide_key(core_wide_key),
    .core_key_init(core_key_init), .core_block_next(core_block_next),
    .core_key(core_key), .core_block(core_block),
    .core_ready(core_ready), .core_result(core_result),
    .core_result_valid(core_result_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apb_write(input logic [15:0] a, input logic [31:0] d,
                           input bit raise_ready = 1'b0);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    if (raise_ready) core_ready = 1'b1;
    @(posedge pclk);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge pclk);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "key", core_key, '0);
    chk("R1", "block", core_block, '0);
    chk("R1", "modes+strobes", {core_encrypt, core_wide_key, core_key_init, core_block_next}, '0);
    chk("R1", "irq", irq, 1'b0);
    apb_read(16'h0000, d); chk("R1", "status", d, '0);
    apb_read(16'h0038, d); chk("R1", "result0", d, '0);
    apb_read(16'hFF00, d); chk("R1", "enable", d, '0);
    apb_read(16'hFF04, d); chk("R1", "masked", d, '0);
    apb_read(16'hFF08, d); chk("R1", "raw", d, '0);
  endtask

  // R2, R3
  task automatic t_ctrl();
    apb_write(16'h0004, 32'h5);
    chk("R2", "key strobe high", core_key_init, 1'b1);
    chk("R2", "block strobe idle", core_block_next, 1'b0);
    chk("R3", "encrypt set", core_encrypt, 1'b1);
    chk("R3", "narrow key", core_wide_key, 1'b0);
    @(negedge pclk);
    chk("R2", "key strobe self-clear", core_key_init, 1'b0);
    chk("R3", "encrypt held", core_encrypt, 1'b1);
    apb_write(16'h0004, 32'hA);
    chk("R2", "block strobe high", core_block_next, 1'b1);
    chk("R2", "key strobe idle", core_key_init, 1'b0);
    chk("R3", "decrypt", core_encrypt, 1'b0);
    chk("R3", "wide key", core_wide_key, 1'b1);
    @(negedge pclk);
    chk("R2", "block strobe self-clear", core_block_next, 1'b0);
    apb_write(16'h0004, 32'h8);
    chk("R2", "no strobe", {core_key_init, core_block_next}, 2'b00);
    chk("R3", "wide held", core_wide_key, 1'b1);
  endtask

  // R4
  task automatic t_data();
    logic [255:0] ek = '0;
    logic [127:0] eb = '0;
    for (int n = 0; n < 8; n++) begin
      logic [31:0] w = 32'hC0DE0000 + 32'(n) * 32'h1111;
      apb_write(16'(8 + 4 * n), w);
      ek[n*32 +: 32] = w;
    end
    chk("R4", "all key words", core_key, ek);
    apb_write(16'h001C, 32'hFFFF0000);
    ek[5*32 +: 32] = 32'hFFFF0000;
    chk("R4", "single key word", core_key, ek);
    for (int n = 0; n < 4; n++) begin
      logic [31:0] w = 32'h5A5A0000 + 32'(n);
      apb_write(16'(16'h0028 + 4 * n), w);
      eb[n*32 +: 32] = w;
    end
    chk("R4", "all block words", core_block, {128'b0, eb});
    chk("R4", "key untouched by block", core_key, ek);
  endtask

  // R5, R6
  task automatic t_status_result();
    logic [31:0] d;
    @(negedge pclk); core_ready = 1'b1; core_result_valid = 1'b0;
    apb_read(16'h0000, d); chk("R5", "ready only", d, 32'h40);
    @(negedge pclk); core_result_valid = 1'b1;
    apb_read(16'h0000, d); chk("R5", "ready+valid", d, 32'hC0);
    @(negedge pclk); core_ready = 1'b0;
    apb_read(16'h0000, d); chk("R5", "valid only", d, 32'h80);
    core_result = 128'h0123456789ABCDEF_FEDCBA9876543210;
    for (int n = 0; n < 4; n++) begin
      apb_read(16'(16'h0038 + 4 * n), d);
      chk("R6", "result word", d, core_result[n*32 +: 32]);
    end
  endtask

  // R7, R8, R9
  task automatic t_irq();
    logic [31:0] d;
    @(negedge pclk); core_ready = 1'b0; core_result_valid = 1'b0;
    @(negedge pclk);
    apb_write(16'hFF0C, 32'h3);
    apb_write(16'hFF00, 32'h0);
    apb_read(16'hFF08, d); chk("R9", "cleared start", d, 32'h0);
    @(negedge pclk); core_result_valid = 1'b1;
    @(negedge pclk); core_result_valid = 1'b0;
    apb_read(16'hFF08, d); chk("R7", "valid flag sticks", d, 32'h1);
    apb_read(16'hFF04, d); chk("R8", "masked off", d, 32'h0);
    chk("R8", "irq masked off", irq, 1'b0);
    apb_write(16'hFF04, 32'h3);
    apb_read(16'hFF00, d); chk("R8", "enable after masked write", d, 32'h0);
    apb_read(16'hFF08, d); chk("R8", "raw after masked write", d, 32'h1);
    apb_write(16'hFF00, 32'h1);
    apb_read(16'hFF04, d); chk("R8", "masked on", d, 32'h1);
    chk("R8", "irq on", irq, 1'b1);
    @(negedge pclk); core_ready = 1'b1;
    apb_read(16'hFF08, d); chk("R7", "ready flag", d, 32'h3);
    apb_read(16'hFF04, d); chk("R8", "ready masked", d, 32'h1);
    apb_write(16'hFF0C, 32'h2);
    apb_read(16'hFF08, d); chk("R9", "clear one bit", d, 32'h1);
    apb_write(16'hFF0C, 32'h1);
    apb_read(16'hFF08, d); chk("R9", "clear other bit", d, 32'h0);
    chk("R8", "irq after clear", irq, 1'b0);
    @(negedge pclk); core_ready = 1'b0;
    @(negedge pclk);
    apb_write(16'hFF0C, 32'h2, 1'b1);
    apb_read(16'hFF08, d); chk("R9", "set beats clear", d, 32'h2);
    chk("R8", "irq for unmasked bit", irq, 1'b0);
  endtask

  // R10
  task automatic t_bus();
    logic [31:0] d;
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = 16'h0100; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    #1;
    chk("R10", "pready", pready, 1'b1);
    chk("R10", "pslverr", pslverr, 1'b0);
    chk("R10", "unmapped read", prdata, 32'h0);
    @(posedge pclk); @(negedge pclk); psel = 1'b0; penable = 1'b0;
    apb_read(16'h0004, d); chk("R10", "control reads zero", d, 32'h0);
    apb_read(16'h0008, d); chk("R10", "key reads zero", d, 32'h0);
    apb_read(16'h0028, d); chk("R10", "block reads zero", d, 32'h0);
    apb_read(16'hFF0C, d); chk("R10", "clear reads zero", d, 32'h0);
  endtask

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    core_ready = 1'b0; core_result = '0; core_result_valid = 1'b0;
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);
    t_reset();
    t_ctrl();
    t_data();
    t_bus();
    t_status_result();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge pclk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule